// File: doc/BRIEF.md
# Region-Tagged Address Translator with Page Keys

This block turns a 64-bit virtual address into a physical address. The three most significant address bits choose one of eight region slots. Each slot holds a 24-bit address-space identifier. That identifier, together with the virtual page number, is searched for in a fully associative table of 16 translations.

A translation that hits supplies four things: a physical page number, read/write/execute permission bits and a page key. The page key is then matched against a file of eight key registers. A matching key register can withdraw any of the three permissions. If no key register matches, the lookup reports a key fault. A table miss reports a translation fault, and in that case no key check is made.

Translations stay tagged with their space identifier. A context switch therefore only rewrites region slots and leaves the table untouched. A purge strobe drops every translation of one space identifier. New translations fill the lowest free slot. When the table is full, a rotating victim pointer picks the slot to replace. Page sizes run from 4 KB to 256 MB and are given as a log2 value per translation.

Top module: `region_key_tlb`

## Requirements
- R1: Address bits 63..61 choose one of eight region slots, and the 24-bit identifier held there must equal the translation's identifier for a hit; two region slots holding the same identifier reach the same translations.
- R2: A valid translation hits when its identifier matches and address bits 60 down to its size exponent equal its stored page bits; size exponents are 12 to 28; when several hit, the lowest slot index is used.
- R3: On a grant, physical address bits below the size exponent come from the virtual address and bits at or above it from the stored page number (physical page number = physical address bits 49..12); the output address is zero for every other result.
- R4: When no translation hits, only the translation-fault flag is raised and no key is checked.
- R5: When a translation hits but no key register that is marked valid holds an equal key, only the key-fault flag is raised.
- R6: Access code 0 is read, 1 is write and 2 is execute (permission bit and key disable bit 0, 1, 2 respectively). A lookup is granted when the translation's permission bit for the code is set and the matched key's disable bit for it is clear. Otherwise it is denied. Code 3 is always denied.
- R7: Every lookup request yields exactly one result one cycle later with exactly one of the four flags (translation fault, key fault, denied, granted) set; no result appears without a request.
- R8: An inserted translation goes to the lowest invalid slot; when all slots are valid it replaces the slot named by a victim pointer that starts at 0 after reset and steps by one (wrapping) on each such replacing insertion.
- R9: Rewriting a region slot invalidates no translation; restoring the old identifier makes the same translations reachable again.
- R10: A purge invalidates every translation whose identifier equals the purge identifier and leaves all others valid.
- R11: After reset all translations and key registers are invalid, all region slots hold identifier 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 64 | Virtual address to translate |
| lkAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| rgnWe | input | 1 | Write a region slot |
| rgnIdx | input | 3 | Region slot to write |
| rgnSpace | input | 24 | Address-space identifier to store |
| keyWe | input | 1 | Write a key register |
| keyIdx | input | 3 | Key register to write |
| keyValue | input | 16 | Key value to store |
| keyValid | input | 1 | Valid bit to store with the key |
| keyDis | input | 3 | Disable bits to store (bit0 read, bit1 write, bit2 execute) |
| insWe | input | 1 | Insert a translation |
| insSpace | input | 24 | Identifier of the new translation |
| insPage | input | 49 | Virtual address bits 60..12 of the new translation |
| insSize | input | 5 | Page size exponent, 12 to 28 |
| insPpn | input | 38 | Physical page number (physical address bits 49..12) |
| insRights | input | 3 | Permission bits (bit0 read, bit1 write, bit2 execute) |
| insKey | input | 16 | Page key of the new translation |
| purgeWe | input | 1 | Purge translations of one identifier |
| purgeSpace | input | 24 | Identifier to purge |
| resValid | output | 1 | Result valid, one cycle after a request |
| resTlbMiss | output | 1 | Translation fault |
| resKeyMiss | output | 1 | Key fault |
| resDenied | output | 1 | Access denied by permissions |
| resGrant | output | 1 | Access granted |
| resPa | output | 50 | Physical address when granted, else 0 |

## Verification
The hardest situation to reach is replacement by the victim pointer. The pointer moves only when every slot is valid, and a purge beforehand leaves holes in the middle of the table. The stimulus first empties two low slots with a purge while two higher slots stay live. It then inserts exactly enough translations to close every hole and the tail. After that, two more insertions must evict slots 0 and 1 in order, and lookups of the evicted and surviving pages show the result. Key faults from an invalid key register and from a key that is absent, together with the region rewrite-and-restore case, are reached by programming the region and key files before the lookups.

// File: rtl/rkt_pkg.sv
package rkt_pkg;

  // strobes handed from control to the datapath each cycle
  typedef struct packed {
    logic regionWr;
    logic keyWr;
    logic ins;
    logic purge;
  } rkt_strobe_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } rkt_access_e;

endpackage

// File: rtl/rkt_datapath.sv
module rkt_datapath
  import rkt_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 50,
  parameter int SPACE_W   = 24,
  parameter int KEY_W     = 16,
  parameter int ENTRIES   = 16,
  parameter int KEYS      = 8,
  parameter int REGIONS   = 8,
  parameter int MIN_SHIFT = 12,
  parameter int SIZE_W    = 5,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int KIDX_W   = $clog2(KEYS),
  localparam int RSEL_W   = $clog2(REGIONS),
  localparam int PG_W     = VA_W - RSEL_W - MIN_SHIFT,
  localparam int PPN_W    = PA_W - MIN_SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  rkt_strobe_t         st,
  input  logic [IDX_W-1:0]    insSlot,
  input  logic [RSEL_W-1:0]   rgnIdx,
  input  logic [SPACE_W-1:0]  rgnSpace,
  input  logic [KIDX_W-1:0]   keyIdx,
  input  logic [KEY_W-1:0]    keyValue,
  input  logic                keyValidIn,
  input  logic [2:0]          keyDisIn,
  input  logic [SPACE_W-1:0]  insSpace,
  input  logic [PG_W-1:0]     insPage,
  input  logic [SIZE_W-1:0]   insSize,
  input  logic [PPN_W-1:0]    insPpn,
  input  logic [2:0]          insRights,
  input  logic [KEY_W-1:0]    insKey,
  input  logic [SPACE_W-1:0]  purgeSpace,
  input  logic [VA_W-1:0]     lkVa,
  input  logic [1:0]          lkAccess,
  output logic [ENTRIES-1:0]  validVec,
  output logic                hit,
  output logic                keyFound,
  output logic                allowed,
  output logic [PA_W-1:0]     pa
);

  logic [SPACE_W-1:0] regionTab [REGIONS];
  logic [ENTRIES-1:0] entValid;
  logic [SPACE_W-1:0] entSpace  [ENTRIES];
  logic [PG_W-1:0]    entPage   [ENTRIES];
  logic [SIZE_W-1:0]  entSize   [ENTRIES];
  logic [PPN_W-1:0]   entPpn    [ENTRIES];
  logic [2:0]         entRights [ENTRIES];
  logic [KEY_W-1:0]   entKey    [ENTRIES];
  logic [KEYS-1:0]    keyOk;
  logic [KEY_W-1:0]   keyVal    [KEYS];
  logic [2:0]         keyDisTab [KEYS];

  // bits of the page number that take part in the compare for a size
  function automatic logic [PG_W-1:0] pageMask(input logic [SIZE_W-1:0] sz);
    logic [PG_W-1:0] one;
    one = {{(PG_W-1){1'b0}}, 1'b1};
    return ~((one << (int'(sz) - MIN_SHIFT)) - one);
  endfunction

  // state with reset: valid bits and region slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      keyOk    <= '0;
      for (int r = 0; r < REGIONS; r++) regionTab[r] <= '0;
    end else begin
      if (st.regionWr) regionTab[rgnIdx] <= rgnSpace;
      if (st.keyWr)    keyOk[keyIdx]     <= keyValidIn;
      for (int i = 0; i < ENTRIES; i++)
        if (st.purge && entSpace[i] == purgeSpace) entValid[i] <= 1'b0;
      if (st.ins) entValid[insSlot] <= 1'b1;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (st.keyWr) begin
      keyVal[keyIdx]    <= keyValue;
      keyDisTab[keyIdx] <= keyDisIn;
    end
    if (st.ins) begin
      entSpace[insSlot]  <= insSpace;
      entPage[insSlot]   <= insPage;
      entSize[insSlot]   <= insSize;
      entPpn[insSlot]    <= insPpn;
      entRights[insSlot] <= insRights;
      entKey[insSlot]    <= insKey;
    end
  end

  assign validVec = entValid;

  // associative search
  logic [SPACE_W-1:0] curSpace;
  logic [PG_W-1:0]    lkPage;
  logic [ENTRIES-1:0] entHit;
  logic [IDX_W-1:0]   selIdx;

  assign curSpace = regionTab[lkVa[VA_W-1 -: RSEL_W]];
  assign lkPage   = lkVa[VA_W-RSEL_W-1:MIN_SHIFT];

  for (genvar g = 0; g < ENTRIES; g++) begin : gen_match
    assign entHit[g] = entValid[g] && (entSpace[g] == curSpace) &&
                       (((lkPage ^ entPage[g]) & pageMask(entSize[g])) == '0);
  end

  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (entHit[i]) selIdx = IDX_W'(i);
  end

  assign hit = |entHit;

  // physical address assembly
  logic [PA_W-1:0] offMask;
  assign offMask = (PA_W'(1) << entSize[selIdx]) - PA_W'(1);
  assign pa = ({entPpn[selIdx], {MIN_SHIFT{1'b0}}} & ~offMask) |
              (lkVa[PA_W-1:0] & offMask);

  // key file search
  logic [KEYS-1:0]   keyHit;
  logic [KIDX_W-1:0] selKey;

  for (genvar k = 0; k < KEYS; k++) begin : gen_key
    assign keyHit[k] = keyOk[k] && (keyVal[k] == entKey[selIdx]);
  end

  always_comb begin
    selKey = '0;
    for (int k = KEYS - 1; k >= 0; k--)
      if (keyHit[k]) selKey = KIDX_W'(k);
  end

  assign keyFound = |keyHit;

  always_comb begin
    case (lkAccess)
      ACC_READ:  allowed = entRights[selIdx][0] && !keyDisTab[selKey][0];
      ACC_WRITE: allowed = entRights[selIdx][1] && !keyDisTab[selKey][1];
      ACC_EXEC:  allowed = entRights[selIdx][2] && !keyDisTab[selKey][2];
      default:   allowed = 1'b0;
    endcase
  end

  // checks on table maintenance
  logic [SPACE_W-1:0] purgeSpaceQ;
  logic               purgeLeft;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) purgeSpaceQ <= '0;
    else       purgeSpaceQ <= purgeSpace;

  always_comb begin
    purgeLeft = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (entValid[i] && entSpace[i] == purgeSpaceQ) purgeLeft = 1'b1;
  end

  p_insert_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.ins |=> entValid[$past(insSlot)]);

  p_region_keeps_entries_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.regionWr && !st.ins && !st.purge) |=> (entValid == $past(entValid)));

  p_purge_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.purge && !st.ins) |=> !purgeLeft);

endmodule

// File: rtl/rkt_ctrl.sv
module rkt_ctrl
  import rkt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 50,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               rgnWe,
  input  logic               keyWe,
  input  logic               insWe,
  input  logic               purgeWe,
  input  logic [ENTRIES-1:0] validVec,
  input  logic               hit,
  input  logic               keyFound,
  input  logic               allowed,
  input  logic [PA_W-1:0]    pa,
  output rkt_strobe_t        st,
  output logic [IDX_W-1:0]   insSlot,
  output logic               resValid,
  output logic               resTlbMiss,
  output logic               resKeyMiss,
  output logic               resDenied,
  output logic               resGrant,
  output logic [PA_W-1:0]    resPa
);

  always_comb begin
    st.regionWr = rgnWe;
    st.keyWr    = keyWe;
    st.ins      = insWe;
    st.purge    = purgeWe;
  end

  // slot choice for insertion
  logic [IDX_W-1:0] freeIdx, victim;
  logic             tableFull;

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) freeIdx = IDX_W'(i);
  end

  assign tableFull = &validVec;
  assign insSlot   = tableFull ? victim : freeIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) victim <= '0;
    else if (insWe && tableFull)
      victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
  end

  // result register
  logic granted;
  assign granted = hit && keyFound && allowed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resTlbMiss <= 1'b0;
      resKeyMiss <= 1'b0;
      resDenied  <= 1'b0;
      resGrant   <= 1'b0;
      resPa      <= '0;
    end else begin
      resValid   <= lkValid;
      resTlbMiss <= lkValid && !hit;
      resKeyMiss <= lkValid && hit && !keyFound;
      resDenied  <= lkValid && hit && keyFound && !allowed;
      resGrant   <= lkValid && granted;
      resPa      <= (lkValid && granted) ? pa : '0;
    end
  end

  p_result_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> resValid);

  p_no_spurious_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !resValid);

  p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($countones({resTlbMiss, resKeyMiss, resDenied, resGrant}) == 1));

  p_miss_skips_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    resTlbMiss |-> (!resKeyMiss && !resGrant && !resDenied));

  p_pa_only_on_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    !resGrant |-> (resPa == '0));

endmodule

// File: rtl/region_key_tlb.sv
module region_key_tlb
  import rkt_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 50,
  parameter int SPACE_W   = 24,
  parameter int KEY_W     = 16,
  parameter int ENTRIES   = 16,
  parameter int KEYS      = 8,
  parameter int REGIONS   = 8,
  parameter int MIN_SHIFT = 12,
  parameter int SIZE_W    = 5,
  localparam int KIDX_W   = $clog2(KEYS),
  localparam int RSEL_W   = $clog2(REGIONS),
  localparam int PG_W     = VA_W - RSEL_W - MIN_SHIFT,
  localparam int PPN_W    = PA_W - MIN_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic [VA_W-1:0]    lkVa,
  input  logic [1:0]         lkAccess,
  input  logic               rgnWe,
  input  logic [RSEL_W-1:0]  rgnIdx,
  input  logic [SPACE_W-1:0] rgnSpace,
  input  logic               keyWe,
  input  logic [KIDX_W-1:0]  keyIdx,
  input  logic [KEY_W-1:0]   keyValue,
  input  logic               keyValid,
  input  logic [2:0]         keyDis,
  input  logic               insWe,
  input  logic [SPACE_W-1:0] insSpace,
  input  logic [PG_W-1:0]    insPage,
  input  logic [SIZE_W-1:0]  insSize,
  input  logic [PPN_W-1:0]   insPpn,
  input  logic [2:0]         insRights,
  input  logic [KEY_W-1:0]   insKey,
  input  logic               purgeWe,
  input  logic [SPACE_W-1:0] purgeSpace,
  output logic               resValid,
  output logic               resTlbMiss,
  output logic               resKeyMiss,
  output logic               resDenied,
  output logic               resGrant,
  output logic [PA_W-1:0]    resPa
);

  localparam int IDX_W = $clog2(ENTRIES);

  rkt_strobe_t        st;
  logic [IDX_W-1:0]   insSlot;
  logic [ENTRIES-1:0] validVec;
  logic               hit, keyFound, allowed;
  logic [PA_W-1:0]    pa;

  rkt_ctrl #(.ENTRIES(ENTRIES), .PA_W(PA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .lkValid(lkValid),
    .rgnWe(rgnWe), .keyWe(keyWe), .insWe(insWe), .purgeWe(purgeWe),
    .validVec(validVec), .hit(hit), .keyFound(keyFound), .allowed(allowed), .pa(pa),
    .st(st), .insSlot(insSlot),
    .resValid(resValid), .resTlbMiss(resTlbMiss), .resKeyMiss(resKeyMiss),
    .resDenied(resDenied), .resGrant(resGrant), .resPa(resPa)
  );

  rkt_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .SPACE_W(SPACE_W), .KEY_W(KEY_W),
    .ENTRIES(ENTRIES), .KEYS(KEYS), .REGIONS(REGIONS),
    .MIN_SHIFT(MIN_SHIFT), .SIZE_W(SIZE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .insSlot(insSlot),
    .rgnIdx(rgnIdx), .rgnSpace(rgnSpace),
    .keyIdx(keyIdx), .keyValue(keyValue), .keyValidIn(keyValid), .keyDisIn(keyDis),
    .insSpace(insSpace), .insPage(insPage), .insSize(insSize), .insPpn(insPpn),
    .insRights(insRights), .insKey(insKey), .purgeSpace(purgeSpace),
    .lkVa(lkVa), .lkAccess(lkAccess),
    .validVec(validVec), .hit(hit), .keyFound(keyFound), .allowed(allowed), .pa(pa)
  );

endmodule

// File: tb/region_key_tlb_tb_top.sv
module region_key_tlb_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        lkValid;
  logic [63:0] lkVa;
  logic [1:0]  lkAccess;
  logic        rgnWe;
  logic [2:0]  rgnIdx;
  logic [23:0] rgnSpace;
  logic        keyWe;
  logic [2:0]  keyIdx;
  logic [15:0] keyValue;
  logic        keyValid;
  logic [2:0]  keyDis;
  logic        insWe;
  logic [23:0] insSpace;
  logic [48:0] insPage;
  logic [4:0]  insSize;
  logic [37:0] insPpn;
  logic [2:0]  insRights;
  logic [15:0] insKey;
  logic        purgeWe;
  logic [23:0] purgeSpace;
  logic        resValid, resTlbMiss, resKeyMiss, resDenied, resGrant;
  logic [49:0] resPa;

  region_key_tlb dut_i (.*);

  typedef struct {
    string       req;
    logic        miss, kmiss, den, grant;
    logic [49:0] pa;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference model state
  logic [23:0] mRegion [8];
  bit          mValid  [16];
  logic [23:0] mSpace  [16];
  logic [63:0] mVa     [16];
  int          mSize   [16];
  logic [37:0] mPpn    [16];
  logic [2:0]  mRights [16];
  logic [15:0] mKey    [16];
  bit          mKOk    [8];
  logic [15:0] mKVal   [8];
  logic [2:0]  mKDis   [8];
  int          mPtr = 0;

  task automatic checkVal(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(string req, logic [63:0] va, logic [1:0] acc);
    exp_t e;
    int hitI = -1;
    int keyI = -1;
    logic [23:0] sp;
    logic [63:0] base, m;
    e.req = req; e.miss = 0; e.kmiss = 0; e.den = 0; e.grant = 0; e.pa = '0;
    sp = mRegion[va[63:61]];
    for (int i = 0; i < 16; i++)
      if (hitI < 0 && mValid[i] && mSpace[i] == sp &&
          ((64'(va[60:0]) >> mSize[i]) == (64'(mVa[i][60:0]) >> mSize[i])))
        hitI = i;
    if (hitI < 0) e.miss = 1;
    else begin
      for (int k = 0; k < 8; k++)
        if (keyI < 0 && mKOk[k] && mKVal[k] == mKey[hitI]) keyI = k;
      if (keyI < 0) e.kmiss = 1;
      else if (acc != 2'd3 && mRights[hitI][int'(acc)] && !mKDis[keyI][int'(acc)]) begin
        e.grant = 1;
        base = {14'b0, mPpn[hitI], 12'b0};
        m = (64'd1 << mSize[hitI]) - 64'd1;
        e.pa = 50'((base & ~m) | (va & m));
      end else e.den = 1;
    end
    return e;
  endfunction

  // monitor: pops one expectation per result
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) checkVal("R7", "unexpected result", 64'd1, 64'd0);
      else begin
        cur = expQ.pop_front();
        checkVal(cur.req, "result {miss,kmiss,den,grant,pa}",
                 {10'b0, resTlbMiss, resKeyMiss, resDenied, resGrant, resPa},
                 {10'b0, cur.miss, cur.kmiss, cur.den, cur.grant, cur.pa});
      end
    end
  end

  task automatic lookup(string req, logic [63:0] va, logic [1:0] acc);
    @(negedge clk);
    expQ.push_back(model(req, va, acc));
    lkValid = 1; lkVa = va; lkAccess = acc;
    @(negedge clk);
    lkValid = 0;
  endtask

  task automatic setRegion(int idx, logic [23:0] sp);
    @(negedge clk);
    rgnWe = 1; rgnIdx = 3'(idx); rgnSpace = sp;
    mRegion[idx] = sp;
    @(negedge clk);
    rgnWe = 0;
  endtask

  task automatic setKey(int idx, logic [15:0] v, bit ok, logic [2:0] dis);
    @(negedge clk);
    keyWe = 1; keyIdx = 3'(idx); keyValue = v; keyValid = ok; keyDis = dis;
    mKOk[idx] = ok; mKVal[idx] = v; mKDis[idx] = dis;
    @(negedge clk);
    keyWe = 0;
  endtask

  task automatic insert(logic [23:0] sp, logic [48:0] pg, int sz, logic [37:0] ppn,
                        logic [2:0] rights, logic [15:0] key);
    int slot = -1;
    @(negedge clk);
    insWe = 1; insSpace = sp; insPage = pg; insSize = 5'(sz);
    insPpn = ppn; insRights = rights; insKey = key;
    for (int i = 0; i < 16; i++) if (slot < 0 && !mValid[i]) slot = i;
    if (slot < 0) begin slot = mPtr; mPtr = (mPtr + 1) % 16; end
    mValid[slot] = 1; mSpace[slot] = sp; mVa[slot] = {3'b0, pg, 12'b0};
    mSize[slot] = sz; mPpn[slot] = ppn; mRights[slot] = rights; mKey[slot] = key;
    @(negedge clk);
    insWe = 0;
  endtask

  task automatic purge(logic [23:0] sp);
    @(negedge clk);
    purgeWe = 1; purgeSpace = sp;
    for (int i = 0; i < 16; i++) if (mSpace[i] == sp) mValid[i] = 0;
    @(negedge clk);
    purgeWe = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mRegion[i] = '0; mKOk[i] = 0; mKVal[i] = '0; mKDis[i] = '0; end
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 0; mSpace[i] = '0; mVa[i] = '0; mSize[i] = 12;
      mPpn[i] = '0; mRights[i] = '0; mKey[i] = '0;
    end
    rstN = 0; lkValid = 0; lkVa = '0; lkAccess = '0;
    rgnWe = 0; rgnIdx = '0; rgnSpace = '0;
    keyWe = 0; keyIdx = '0; keyValue = '0; keyValid = 0; keyDis = '0;
    insWe = 0; insSpace = '0; insPage = '0; insSize = 5'd12; insPpn = '0;
    insRights = '0; insKey = '0; purgeWe = 0; purgeSpace = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11: outputs idle after reset
    checkVal("R11", "outputs after reset",
             {13'b0, resValid, resTlbMiss, resKeyMiss, resDenied, resGrant, resPa}, 64'd0);
    lookup("R11 empty table misses", 64'h0000_0000_1234_5000, 2'd0);

    setRegion(0, 24'hA1);
    setRegion(5, 24'hA1);
    setRegion(1, 24'hB2);
    setKey(0, 16'h0011, 1, 3'b000);
    setKey(1, 16'h0022, 1, 3'b001);
    setKey(2, 16'h0033, 0, 3'b000);

    // 4 KB page, read+write, key 0x0011
    insert(24'hA1, 49'h0_1234_5, 12, 38'h0_000A_BCDE, 3'b011, 16'h0011);
    lookup("R3 4K read grant", 64'h0000_0000_1234_5678, 2'd0);
    lookup("R6 write grant", 64'h0000_0000_1234_5ABC, 2'd1);
    lookup("R6 exec denied by rights", 64'h0000_0000_1234_5000, 2'd2);
    lookup("R6 code 3 denied", 64'h0000_0000_1234_5000, 2'd3);
    lookup("R1 shared space via region 5", 64'hA000_0000_1234_5FFF, 2'd0);
    lookup("R1 other region misses", 64'h2000_0000_1234_5000, 2'd0);
    lookup("R2 neighbour page misses", 64'h0000_0000_1234_6000, 2'd0);
    lookup("R4 miss", 64'h0000_0001_0000_0000, 2'd1);

    // 2 MB page, all rights, key with read disabled
    insert(24'hA1, 49'h0_4000_0, 21, 38'h1_2340_0000 >> 0, 3'b111, 16'h0022);
    lookup("R6 key disables read", 64'h0000_0000_401F_F123, 2'd0);
    lookup("R3 2M write grant offset", 64'h0000_0000_401F_F123, 2'd1);
    lookup("R2 2M page boundary misses", 64'h0000_0000_4020_0000, 2'd1);

    // 256 MB page with invalid key register, and key absent from file
    insert(24'hB2, 49'h0_8000_0, 28, 38'h3_0000_0000, 3'b111, 16'h0033);
    insert(24'hB2, 49'h1_0000_0, 28, 38'h3_1000_0000, 3'b111, 16'h0099);
    lookup("R5 invalid key register", 64'h2000_0000_8ABC_DEF0, 2'd0);
    lookup("R5 key absent", 64'h2000_0001_0FFF_FFFF, 2'd0);
    setKey(2, 16'h0033, 1, 3'b000);
    lookup("R3 256M grant", 64'h2000_0000_8ABC_DEF0, 2'd2);

    // R9: region rewrite leaves translations intact
    setRegion(1, 24'hC3);
    lookup("R9 rewritten region misses", 64'h2000_0000_8ABC_DEF0, 2'd0);
    setRegion(1, 24'hB2);
    lookup("R9 restored region hits", 64'h2000_0000_8ABC_DEF0, 2'd0);

    // R10: purge one space
    purge(24'hA1);
    lookup("R10 purged 4K entry", 64'h0000_0000_1234_5678, 2'd0);
    lookup("R10 purged 2M entry", 64'h0000_0000_401F_F123, 2'd1);
    lookup("R10 other space kept", 64'h2000_0000_8ABC_DEF0, 2'd0);

    // R8: refill, then round-robin replacement
    setRegion(2, 24'h77);
    for (int n = 0; n < 14; n++)
      insert(24'h77, 49'(n), 12, 38'(100 + n), 3'b001, 16'h0011);
    lookup("R8 fill page 13", 64'h4000_0000_0000_D010, 2'd0);
    insert(24'h77, 49'd14, 12, 38'd114, 3'b001, 16'h0011);
    lookup("R8 victim slot 0 evicted", 64'h4000_0000_0000_0010, 2'd0);
    lookup("R8 new page 14", 64'h4000_0000_0000_E010, 2'd0);
    lookup("R8 page 1 still live", 64'h4000_0000_0000_1010, 2'd0);
    insert(24'h77, 49'd15, 12, 38'd115, 3'b001, 16'h0011);
    lookup("R8 victim slot 1 evicted", 64'h4000_0000_0000_1010, 2'd0);
    lookup("R8 page 2 still live", 64'h4000_0000_0000_2010, 2'd0);
    lookup("R8 slot 2 256M kept", 64'h2000_0000_8000_0000, 2'd0);

    repeat (3) @(negedge clk);
    checkVal("R7", "outstanding expectations", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule